// File: doc/BRIEF.md
# Vector-to-Predicate Bitmap Unpacker

This block turns a packed bitmap held in a wide vector operand into a predicate value. A set bitmap bit stands for TRUE and a clear bit for FALSE. The predicate is one eighth as wide as the vector. It is divided into elements whose width follows the selected element size: 1, 2, 4 or 8 predicate bits for 8-, 16-, 32- and 64-bit elements. Each bitmap bit goes into the lowest bit of its element, and the other bits of that element are cleared. A portion index picks which slice of the vector supplies the bitmap. The number of elements is the vector length VL divided by the element size, and element e reads vector bit (elements × index) + e.

A small decoder takes a 32-bit instruction word. From it the decoder derives the element size, the portion index, a 5-bit source vector register number and a 4-bit destination predicate register number. A word that fits none of the four size patterns is flagged invalid, and the predicate for it is forced to zero. With the default output register, a strobe on `in_valid` captures the result. The result, the decoded fields and the invalid flag then appear on the next clock, together with a one-cycle `out_valid`.

The output stage has two named states. OS_IDLE means no result is being presented. OS_SHOW means a captured result is being presented. Transitions: IDLE→SHOW and SHOW→SHOW on a strobe; SHOW→IDLE and IDLE→IDLE without one. Reset enters OS_IDLE.

Top module: `vec2pred_unpack`

## Requirements
- R1: For 8-bit elements (size field 0), predicate bit j equals vector bit j for every j below VL/8.
- R2: For element size 2^(3+s) bits (s = 0..3), predicate element e spans bits [e·2^s +: 2^s]. Its lowest bit carries the bitmap bit and all higher bits are 0.
- R3: The portion index k selects the source bit: element e takes vector bit (VL/2^(3+s))·k + e. Legal k is 0 for 8-bit, 0–1 for 16-bit, 0–3 for 32-bit and 0–7 for 64-bit elements.
- R4: Instruction bits [31:24] must be 8'b00000101, bits [16:10] must be 7'b0001110 and bit 4 must be 0. Size is chosen by bits [23:17]: 7'b0010101 is 8-bit; [23:18]=6'b001011 is 16-bit; [23:19]=5'b01101 is 32-bit; bit 23=1 with [21:19]=3'b101 is 64-bit.
- R5: The portion index is taken from bit 17 for 16-bit elements, bits [18:17] for 32-bit elements, and {bit 22, bits [18:17]} for 64-bit elements. It is 0 for 8-bit elements.
- R6: `src_reg` is instruction bits [9:5] and `dst_reg` is bits [3:0].
- R7: A word that breaks any rule of R4 sets `out_bad`, and `pred` is then all zeros.
- R8: A strobe on `in_valid` makes `out_valid` high for the following cycle, with the result of that strobe's inputs.
- R9: In a cycle without a strobe, `pred` keeps its last value whatever the vector and instruction inputs do.
- R10: Reset clears `pred` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: capture the current operands |
| instr | input | 32 | Instruction word to decode |
| vec | input | VL | Vector operand holding the bitmap |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| pred | output | VL/8 | Predicate result |
| out_bad | output | 1 | Instruction word matched no size pattern |
| src_reg | output | 5 | Source vector register number |
| dst_reg | output | 4 | Destination predicate register number |

## Verification
A fresh capture and the presentation of the previous result can fall in the same cycle. So can a valid decode and an invalid one, when strobes arrive back to back. The bench strobes on every cycle through long runs. In some of these runs an invalid word directly follows a legal one. Each cycle must then show the predicate of its own word: `out_valid` stays high, and `pred` drops to zero exactly on the cycle that presents the invalid word.

// File: rtl/vec2pred_pkg.sv
package vec2pred_pkg;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_S = 2'd2,
        SZ_D = 2'd3
    } esize_e;

    typedef struct packed {
        logic       bad;
        esize_e     size;
        logic [2:0] idx;
        logic [4:0] src;
        logic [3:0] dst;
    } dec_t;

endpackage

// File: rtl/vec2pred_decode.sv
module vec2pred_decode
    import vec2pred_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);

    localparam logic [7:0] TOP_BYTE = 8'b0000_0101;
    localparam logic [6:0] MID_BITS = 7'b0001110;

    logic fixed_ok;
    logic m_b, m_h, m_s, m_d;

    always_comb begin
        fixed_ok = (instr[31:24] == TOP_BYTE) && (instr[16:10] == MID_BITS) && !instr[4];
        m_b      = (instr[23:17] == 7'b0010101);
        m_h      = (instr[23:18] == 6'b001011);
        m_s      = (instr[23:19] == 5'b01101);
        m_d      = instr[23] && (instr[21:19] == 3'b101);

        dec.src  = instr[9:5];
        dec.dst  = instr[3:0];
        dec.bad  = !(fixed_ok && (m_b || m_h || m_s || m_d));
        dec.size = SZ_B;
        dec.idx  = 3'd0;
        if (m_d) begin
            dec.size = SZ_D;
            dec.idx  = {instr[22], instr[18:17]};
        end else if (m_s) begin
            dec.size = SZ_S;
            dec.idx  = {1'b0, instr[18:17]};
        end else if (m_h) begin
            dec.size = SZ_H;
            dec.idx  = {2'b00, instr[17]};
        end
    end

endmodule

// File: rtl/vec2pred_spread.sv
module vec2pred_spread
    import vec2pred_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic [VL-1:0]   vec,
    input  esize_e          size,
    input  logic [2:0]      idx,
    input  logic            bad,
    output logic [VL/8-1:0] pred
);

    localparam int PW   = VL / 8;
    localparam int LOGV = $clog2(VL);
    localparam int SH_H = LOGV - 4;
    localparam int SH_S = LOGV - 5;
    localparam int SH_D = LOGV - 6;

    logic [LOGV-1:0] base;
    logic [PW-1:0]   slice;
    logic [PW-1:0]   raw;

    always_comb begin
        unique case (size)
            SZ_B: base = '0;
            SZ_H: base = LOGV'(idx[0])   << SH_H;
            SZ_S: base = LOGV'(idx[1:0]) << SH_S;
            SZ_D: base = LOGV'(idx)      << SH_D;
        endcase
        slice = vec[base +: PW];
    end

    for (genvar j = 0; j < PW; j++) begin : g_bit
        logic hb, sb, db;
        if (j % 2 == 0) begin : g_h
            assign hb = slice[j/2];
        end else begin : g_hz
            assign hb = 1'b0;
        end
        if (j % 4 == 0) begin : g_s
            assign sb = slice[j/4];
        end else begin : g_sz
            assign sb = 1'b0;
        end
        if (j % 8 == 0) begin : g_d
            assign db = slice[j/8];
        end else begin : g_dz
            assign db = 1'b0;
        end
        always_comb begin
            unique case (size)
                SZ_B: raw[j] = slice[j];
                SZ_H: raw[j] = hb;
                SZ_S: raw[j] = sb;
                SZ_D: raw[j] = db;
            endcase
        end
    end

    assign pred = bad ? '0 : raw;

    function automatic logic [PW-1:0] upper_mask(input esize_e s);
        logic [PW-1:0] m;
        m = '0;
        for (int k = 0; k < PW; k++) begin
            if ((k & ((1 << s) - 1)) != 0) m[k] = 1'b1;
        end
        return m;
    endfunction

    always_comb begin
        AST_ELEM_UPPER_CLEAR: assert ((pred & upper_mask(size)) == '0); // R2
        if (!bad && size == SZ_B) begin
            AST_BYTE_COPY: assert (pred == vec[PW-1:0]); // R1
        end
    end

endmodule

// File: rtl/vec2pred_unpack.sv
module vec2pred_unpack
    import vec2pred_pkg::*;
#(
    parameter int VL      = 256,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [VL-1:0]   vec,
    output logic            out_valid,
    output logic [VL/8-1:0] pred,
    output logic            out_bad,
    output logic [4:0]      src_reg,
    output logic [3:0]      dst_reg
);

    localparam int PW = VL / 8;

    dec_t          dec;
    logic [PW-1:0] pred_c;

    vec2pred_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    vec2pred_spread #(.VL(VL)) u_spread (
        .vec  (vec),
        .size (dec.size),
        .idx  (dec.idx),
        .bad  (dec.bad),
        .pred (pred_c)
    );

    if (REG_OUT) begin : g_reg
        typedef enum logic {OS_IDLE, OS_SHOW} ostate_e;
        ostate_e       state, state_nx;
        logic [PW-1:0] pred_q;
        logic          bad_q;
        logic [4:0]    src_q;
        logic [3:0]    dst_q;

        always_comb begin
            unique case (state)
                OS_IDLE: state_nx = in_valid ? OS_SHOW : OS_IDLE;
                OS_SHOW: state_nx = in_valid ? OS_SHOW : OS_IDLE;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) state <= OS_IDLE;
            else        state <= state_nx;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pred_q <= '0;
                bad_q  <= 1'b0;
                src_q  <= '0;
                dst_q  <= '0;
            end else if (in_valid) begin
                pred_q <= pred_c;
                bad_q  <= dec.bad;
                src_q  <= dec.src;
                dst_q  <= dec.dst;
            end
        end

        assign out_valid = (state == OS_SHOW);
        assign pred      = pred_q;
        assign out_bad   = bad_q;
        assign src_reg   = src_q;
        assign dst_reg   = dst_q;

        AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R8
        AST_BAD_ZEROES_PRED: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_bad) |-> (pred == '0)); // R7
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(pred)); // R9
    end else begin : g_comb
        assign out_valid = in_valid;
        assign pred      = pred_c;
        assign out_bad   = dec.bad;
        assign src_reg   = dec.src;
        assign dst_reg   = dec.dst;
    end

endmodule

// File: tb/vec2pred_unpack_tb.sv
`timescale 1ns/1ps
module vec2pred_unpack_tb;

    localparam int VL = 256;
    localparam int PW = VL / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic [VL-1:0] vec = '0;
    logic          out_valid;
    logic [PW-1:0] pred;
    logic          out_bad;
    logic [4:0]    src_reg;
    logic [3:0]    dst_reg;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vec2pred_unpack #(.VL(VL), .REG_OUT(1'b1)) u_dut (
        .clk, .rst_n, .in_valid, .instr, .vec,
        .out_valid, .pred, .out_bad, .src_reg, .dst_reg
    );

    function automatic logic [31:0] make_word(int sz, int k, int zn, int pd);
        logic [31:0] w;
        w = 32'h0500_3800;
        w[9:5] = 5'(zn);
        w[3:0] = 4'(pd);
        case (sz)
            0: w[23:17] = 7'b0010101;
            1: begin w[23:18] = 6'b001011; w[17] = k[0]; end
            2: begin w[23:19] = 5'b01101; w[18:17] = k[1:0]; end
            default: begin
                w[23] = 1'b1; w[22] = k[2]; w[21:19] = 3'b101; w[18:17] = k[1:0];
            end
        endcase
        return w;
    endfunction

    function automatic logic [PW-1:0] ref_pred(logic [VL-1:0] v, int sz, int k);
        logic [PW-1:0] p;
        int psz, elems;
        psz   = 1 << sz;
        elems = VL / (8 << sz);
        p = '0;
        for (int e = 0; e < elems; e++) p[e*psz] = v[elems*k + e];
        return p;
    endfunction

    function automatic logic [VL-1:0] rand_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(string tag, logic [VL-1:0] act, logic [VL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(logic [31:0] w, logic [VL-1:0] v, logic [PW-1:0] ep,
                          logic eb, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        instr    = w;
        vec      = v;
        @(posedge clk);
        #1;
        check({tag, " R8 out_valid"}, VL'(out_valid), VL'(1'b1));
        check({tag, " pred"}, VL'(pred), VL'(ep));
        check({tag, " R7 out_bad"}, VL'(out_bad), VL'(eb));
        if (!eb) begin
            check({tag, " R6 src_reg"}, VL'(src_reg), VL'(w[9:5]));
            check({tag, " R6 dst_reg"}, VL'(dst_reg), VL'(w[3:0]));
        end
    endtask

    task automatic idle_check(logic [PW-1:0] held);
        @(negedge clk);
        in_valid = 1'b0;
        vec      = rand_vec();
        instr    = make_word(3, 5, 1, 2);
        @(posedge clk);
        #1;
        check("R8 out_valid low when idle", VL'(out_valid), VL'(1'b0));
        check("R9 pred held", VL'(pred), VL'(held));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [VL-1:0] v;
        logic [VL-1:0] last_v;
        void'($urandom(32'd7171));

        in_valid = 1'b1;
        instr    = make_word(0, 0, 3, 4);
        vec      = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R10 pred after reset", VL'(pred), '0);
        check("R10 out_valid after reset", VL'(out_valid), '0);

        for (int sz = 0; sz < 4; sz++) begin
            for (int k = 0; k < (1 << sz); k++) begin
                for (int p = 0; p < 7; p++) begin
                    int zn, pd;
                    string tag;
                    case (p)
                        0: v = '1;
                        1: v = {(VL/2){2'b01}};
                        2: v = {(VL/2){2'b10}};
                        default: v = rand_vec();
                    endcase
                    zn  = int'($urandom_range(31));
                    pd  = int'($urandom_range(15));
                    tag = (sz == 0) ? "R1 R4 byte" :
                          $sformatf("R2 R3 R4 R5 size%0d idx%0d", sz, k);
                    run_op(make_word(sz, k, zn, pd), v, ref_pred(v, sz, k), 1'b0, tag);
                end
                idle_check(ref_pred(v, sz, k));
            end
        end

        last_v = rand_vec();
        run_op(make_word(3, 7, 9, 1), last_v, ref_pred(last_v, 3, 7), 1'b0, "R8 b2b legal");
        v = rand_vec();
        run_op(make_word(3, 7, 9, 1) | 32'h10, v, '0, 1'b1, "R7 b2b bit4 set");
        v = rand_vec();
        run_op(make_word(2, 2, 4, 5), v, ref_pred(v, 2, 2), 1'b0, "R8 b2b legal again");
        v = '1;
        run_op(make_word(1, 1, 0, 0) ^ 32'h0100_0000, v, '0, 1'b1, "R7 top byte wrong");
        run_op(make_word(1, 1, 0, 0) ^ 32'h0000_0400, v, '0, 1'b1, "R7 mid field wrong");
        run_op(32'h0500_3800, v, '0, 1'b1, "R7 no size pattern");
        run_op(make_word(0, 0, 0, 0) ^ 32'h0002_0000, v, '0, 1'b1, "R7 byte pattern off");
        idle_check('0);

        for (int n = 0; n < 40; n++) begin
            int sz, k;
            sz = int'($urandom_range(3));
            k  = int'($urandom_range((1 << sz) - 1));
            v  = rand_vec();
            run_op(make_word(sz, k, n % 32, n % 16), v, ref_pred(v, sz, k), 1'b0,
                   "R3 R5 random b2b");
        end
        @(negedge clk);
        in_valid = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule